// File: doc/BRIEF.md
# Synchronous Presettable Cascadable Counter Stage

This block is a one-digit synchronous counter. A parameter chooses between a decade sequence (0 to 9) and a full binary sequence (0 to 15 at the default width of four bits). A second parameter chooses how the active-low clear acts. It can force zero at once, independent of the clock, or it can wait for the next rising edge. Every state change except the asynchronous clear happens together on the rising clock edge, so downstream decode logic sees no ripple glitches.

Each stage has an active-low parallel load, which captures the data inputs on a clock edge. It also has two count enables, and both must be high for the stage to advance. One enable is local. The other doubles as the carry input from a lower stage. A carry output is high when the stage holds its terminal value and its carry input is high.

To build a wider counter, put every stage on the same clock and feed each carry output into the next stage's carry input. Tie the first stage's carry input high. With the synchronous clear variant, a truncated modulus is made by decoding the value one below the desired modulus and driving the clear from that decode.

Top module: `sync_cascade_counter`

## Requirements
- R1: While the clear input is low, the count is 0 at the next rising edge in both variants. In the asynchronous variant, the count becomes 0 as soon as the clear goes low, with no clock edge.
- R2: In the synchronous variant, a low clear leaves the count unchanged until the next rising edge, and that edge sets it to 0.
- R3: In decade mode, with both enables high and load high, each rising edge advances the count by one from 0 up to 9, and 9 is followed by 0.
- R4: In binary mode, each enabled edge advances the count by one from 0 up to 15, and 15 is followed by 0.
- R5: With load low and clear high, a rising edge copies the 4-bit data input into the count. Data bit 0 is the count's least significant bit.
- R6: If either enable is low while clear and load are high, the count holds across clock edges.
- R7: The carry output is high exactly when the count equals the terminal value (9 in decade mode, 15 in binary mode) and the carry input (en_t) is high. This holds regardless of the local enable.
- R8: Clear takes priority over load, and load takes priority over counting.
- R9: In decade mode, an enabled count from any value above 9 (10 to 15) goes to 0 on the next edge, so the sequence never locks up.
- R10: Decade stages on a shared clock, with each carry output driving the next carry input, count as a multi-digit decimal value. The top stage's carry output is high at the all-nines value.
- R11: In the synchronous clear variant, driving the clear from a decode of the value 6 gives a repeating 0 to 6 sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous according to a parameter |
| ld_n | input | 1 | Active-low parallel load, applied on the rising edge |
| en_p | input | 1 | Local count enable |
| en_t | input | 1 | Carry input from the lower stage; also qualifies the carry output |
| d | input | WIDTH | Parallel load data |
| q | output | WIDTH | Current count |
| co | output | 1 | Carry output: terminal count with en_t high |

## Verification
A corrupted count register shows up on q at the first sample after the edge that loaded it. Because the carry output is decoded directly from the count, a wrong terminal value also shows up on co in the same cycle. A wrong next-value choice is caught one cycle after the edge on which it acts. This covers an off-by-one, a wrapped out-of-range code, or a priority inversion between clear, load and count. The scoreboard compares q and co after every driven edge, and the cascade and truncation runs expose any carry error across many cycles as a wrong multi-digit total.

// File: rtl/cntr_pkg.sv
package cntr_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } act_e;

  // Priority: clear, then load, then count (both enables), else hold.
  function automatic act_e choose_action(logic clr_n, logic ld_n,
                                         logic en_p, logic en_t);
    if (!clr_n)            return ACT_CLEAR;
    else if (!ld_n)        return ACT_LOAD;
    else if (en_p && en_t) return ACT_COUNT;
    else                   return ACT_HOLD;
  endfunction

endpackage

// File: rtl/cntr_ctrl.sv
module cntr_ctrl
  import cntr_pkg::*;
(
  input  logic clr_n,
  input  logic ld_n,
  input  logic en_p,
  input  logic en_t,
  output act_e act,
  output logic load_evt,
  output logic cnt_evt,
  output logic hold_evt
);

  always_comb begin
    act      = choose_action(clr_n, ld_n, en_p, en_t);
    load_evt = (act == ACT_LOAD);
    cnt_evt  = (act == ACT_COUNT);
    hold_evt = (act == ACT_HOLD);
  end

endmodule

// File: rtl/cntr_next.sv
module cntr_next
  import cntr_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  act_e             act,
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] nxt
);

  localparam int TERM_I = DECADE ? 9 : (1 << WIDTH) - 1;
  localparam logic [WIDTH-1:0] TERM = WIDTH'(TERM_I);

  // Successor: anything at or above the terminal value returns to zero.
  function automatic logic [WIDTH-1:0] successor(logic [WIDTH-1:0] cur);
    if (cur >= TERM) return '0;
    return cur + 1'b1;
  endfunction

  always_comb begin
    unique case (act)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = d;
      ACT_COUNT: nxt = successor(q);
      default:   nxt = q;
    endcase
  end

endmodule

// File: rtl/cntr_reg.sv
module cntr_reg #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_sync
      // The next-value logic already selects zero while clear is low.
      always_ff @(posedge clk) begin
        q <= nxt;
      end
    end
  endgenerate

  assert_clear_R1: assert property (@(posedge clk) !clr_n |=> q == '0)
    else $error("clear low did not give zero count");

endmodule

// File: rtl/cntr_carry.sv
module cntr_carry #(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             at_term,
  output logic             co
);

  localparam int TERM_I = DECADE ? 9 : (1 << WIDTH) - 1;
  localparam logic [WIDTH-1:0] TERM = WIDTH'(TERM_I);

  always_comb begin
    at_term = (q == TERM);
    co      = at_term & en_t;
  end

endmodule

// File: rtl/sync_cascade_counter.sv
module sync_cascade_counter
  import cntr_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit DECADE    = 1'b1,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             co
);

  localparam int TERM_I = DECADE ? 9 : (1 << WIDTH) - 1;
  localparam logic [WIDTH-1:0] TERM = WIDTH'(TERM_I);

  act_e             act;
  logic             load_evt;
  logic             cnt_evt;
  logic             hold_evt;
  logic             at_term;
  logic [WIDTH-1:0] nxt;

  cntr_ctrl u_ctrl (
    .clr_n    (clr_n),
    .ld_n     (ld_n),
    .en_p     (en_p),
    .en_t     (en_t),
    .act      (act),
    .load_evt (load_evt),
    .cnt_evt  (cnt_evt),
    .hold_evt (hold_evt)
  );

  cntr_next #(.WIDTH(WIDTH), .DECADE(DECADE)) u_next (
    .act (act),
    .q   (q),
    .d   (d),
    .nxt (nxt)
  );

  cntr_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .nxt   (nxt),
    .q     (q)
  );

  cntr_carry #(.WIDTH(WIDTH), .DECADE(DECADE)) u_carry (
    .q       (q),
    .en_t    (en_t),
    .at_term (at_term),
    .co      (co)
  );

  // R5, R8: load wins over counting and captures the data inputs.
  assert_load_R5: assert property (@(posedge clk) disable iff (!clr_n)
    load_evt |=> q == $past(d))
    else $error("load did not capture data");

  // R6: no enable, no change.
  assert_hold_R6: assert property (@(posedge clk) disable iff (!clr_n)
    hold_evt |=> $stable(q))
    else $error("count moved while disabled");

  // R3, R4: in-range count steps by one.
  assert_step_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (cnt_evt && q < TERM) |=> q == WIDTH'($past(q) + 1'b1))
    else $error("count did not advance by one");

  // R7: an asserted carry with counting enabled means the next value is zero.
  assert_carry_wrap_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (co && en_p && ld_n && at_term) |=> q == '0)
    else $error("carry did not precede wrap");

  generate
    if (DECADE) begin : g_dec_chk
      // R9: out-of-range decade codes recover in one enabled edge.
      assert_recover_R9: assert property (@(posedge clk) disable iff (!clr_n)
        (cnt_evt && q > TERM) |=> q == '0)
        else $error("out-of-range code did not recover");
    end
  endgenerate

endmodule

// File: tb/tb_sync_cascade_counter.sv
module tb_sync_cascade_counter;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int nchk = 0;
  int nerr = 0;

  // Decade stage, asynchronous clear (scoreboarded)
  logic       a_clr_n = 1'b0, a_ld_n = 1'b1, a_ep = 1'b1, a_et = 1'b1;
  logic [3:0] a_d = 4'd0;
  wire  [3:0] a_q;
  wire        a_co;

  sync_cascade_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) dut (
    .clk(clk), .clr_n(a_clr_n), .ld_n(a_ld_n), .en_p(a_ep), .en_t(a_et),
    .d(a_d), .q(a_q), .co(a_co));

  // Binary stage, synchronous clear
  logic       b_clr_n = 1'b0, b_ld_n = 1'b1, b_ep = 1'b1, b_et = 1'b1;
  logic [3:0] b_d = 4'd0;
  wire  [3:0] b_q;
  wire        b_co;

  sync_cascade_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_bin (
    .clk(clk), .clr_n(b_clr_n), .ld_n(b_ld_n), .en_p(b_ep), .en_t(b_et),
    .d(b_d), .q(b_q), .co(b_co));

  // Two decade stages in a chain
  logic       c_clr_n = 1'b0;
  wire  [3:0] lo_q, hi_q;
  wire        lo_co, hi_co;

  sync_cascade_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) u_lo (
    .clk(clk), .clr_n(c_clr_n), .ld_n(1'b1), .en_p(1'b1), .en_t(1'b1),
    .d(4'd0), .q(lo_q), .co(lo_co));

  sync_cascade_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) u_hi (
    .clk(clk), .clr_n(c_clr_n), .ld_n(1'b1), .en_p(1'b1), .en_t(lo_co),
    .d(4'd0), .q(hi_q), .co(hi_co));

  // Truncated modulo-7 binary stage
  logic       m_rst_n = 1'b0;
  wire  [3:0] m_q;
  wire        m_co;
  wire        m_clr_n = m_rst_n & (m_q != 4'd6);

  sync_cascade_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_mod (
    .clk(clk), .clr_n(m_clr_n), .ld_n(1'b1), .en_p(1'b1), .en_t(1'b1),
    .d(4'd0), .q(m_q), .co(m_co));

  task automatic check(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Independent model of the decade stage
  logic [3:0] mq = 4'd0;

  function automatic logic [3:0] ref_next(logic [3:0] cur, logic c, logic l,
                                          logic p, logic t, logic [3:0] dv);
    if (!c) return 4'd0;
    if (!l) return dv;
    if (p && t) return (cur > 4'd8) ? 4'd0 : 4'((int'(cur) + 1) % 10);
    return cur;
  endfunction

  logic [3:0] exp_q[$];
  logic       exp_co[$];
  string      exp_tag[$];

  task automatic drive(logic c, logic l, logic p, logic t, logic [3:0] dv,
                       string tag);
    @(negedge clk);
    a_clr_n = c; a_ld_n = l; a_ep = p; a_et = t; a_d = dv;
    mq = ref_next(mq, c, l, p, t, dv);
    exp_q.push_back(mq);
    exp_co.push_back((mq == 4'd9) && t);
    exp_tag.push_back(tag);
  endtask

  // Monitor: compare after each edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [3:0] eq;
      logic       ec;
      string      tg;
      eq = exp_q.pop_front();
      ec = exp_co.pop_front();
      tg = exp_tag.pop_front();
      check(a_q === eq, tg, "q", int'(a_q), int'(eq));
      check(a_co === ec, tg, "co", int'(a_co), int'(ec));
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    #200000;
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // Decade / async stage scoreboard
    drive(1'b0, 1'b1, 1'b1, 1'b1, 4'd0, "R1");
    for (int i = 0; i < 12; i++) drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, "R3");
    drive(1'b1, 1'b0, 1'b1, 1'b1, 4'd9,  "R5");
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'd0,  "R7");   // hold, carry blocked by en_t
    drive(1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  "R6");   // hold, carry shown
    drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  "R7");   // wrap
    drive(1'b1, 1'b0, 1'b1, 1'b1, 4'd13, "R5");
    drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  "R9");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd15, "R5");
    drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  "R9");
    drive(1'b1, 1'b0, 1'b1, 1'b1, 4'd4,  "R8");   // load beats count
    drive(1'b0, 1'b0, 1'b1, 1'b1, 4'd7,  "R8");   // clear beats load
    drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  "R3");
    drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  "R3");
    @(posedge clk); #3;

    // R1: asynchronous clear acts between edges
    @(negedge clk); #1 a_clr_n = 1'b0;
    #1 check(a_q === 4'd0, "R1", "async q", int'(a_q), 0);
    mq = 4'd0;
    drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, "R3");
    @(posedge clk); #3;

    // Binary / sync stage
    @(negedge clk); b_clr_n = 1'b1; b_ld_n = 1'b0; b_d = 4'd12;
    @(posedge clk); #2 check(b_q === 4'd12, "R5", "bin load", int'(b_q), 12);
    @(negedge clk); b_ld_n = 1'b1;
    for (int k = 13; k <= 15; k++) begin
      @(posedge clk); #2 check(b_q === 4'(k), "R4", "bin q", int'(b_q), k);
    end
    check(b_co === 1'b1, "R7", "bin co", int'(b_co), 1);
    @(posedge clk); #2 check(b_q === 4'd0, "R4", "bin wrap", int'(b_q), 0);
    repeat (3) @(posedge clk);
    #2 check(b_q === 4'd3, "R4", "bin q", int'(b_q), 3);
    @(negedge clk); #1 b_clr_n = 1'b0;
    #1 check(b_q === 4'd3, "R2", "sync clear early", int'(b_q), 3);
    @(posedge clk); #2 check(b_q === 4'd0, "R2", "sync clear edge", int'(b_q), 0);
    @(negedge clk); b_clr_n = 1'b1;

    // R10: two-digit decade chain
    @(negedge clk); c_clr_n = 1'b1;
    repeat (37) @(posedge clk);
    #2 check(int'(hi_q) * 10 + int'(lo_q) == 37, "R10", "chain",
             int'(hi_q) * 10 + int'(lo_q), 37);
    repeat (62) @(posedge clk);
    #2 check(int'(hi_q) * 10 + int'(lo_q) == 99, "R10", "chain",
             int'(hi_q) * 10 + int'(lo_q), 99);
    check(hi_co === 1'b1, "R10", "chain co", int'(hi_co), 1);
    @(posedge clk);
    #2 check(hi_q === 4'd0 && lo_q === 4'd0, "R10", "chain wrap",
             int'(hi_q) * 10 + int'(lo_q), 0);

    // R11: truncated count 0..6
    @(negedge clk); m_rst_n = 1'b1;
    for (int k = 1; k <= 14; k++) begin
      @(posedge clk);
      #2 check(m_q === 4'(k % 7), "R11", "mod7", int'(m_q), k % 7);
    end

    finish_run();
  end

endmodule